// File: doc/BRIEF.md
# Parallel Port Handshake Strobe Generator

This block sits beside the data register of an 8-bit parallel port. It gives a peripheral a timed handshake. Every read or write of the port data register from the bus side can start a sequence. After a fixed delay, the active-low strobe pin drops. It then stays low for a fixed number of clocks and rises again. The sequence opens a lockout window. A further data-register access inside that window changes the stored data as usual, but it neither starts a second pulse nor restarts the running one.

A small control register holds two writable bits. One bit allows strobe pulses at all. The other bit lets a busy pin follow the sequence, from the triggering access until the strobe returns high. The two lowest control bits are fixed at one. Delay, pulse width, lockout length and data width are parameters. The defaults are a 7-clock delay, an 8-clock pulse and a 15-clock window.

Top module: `strobe_port_ctrl`

## Requirements
- R1: A write to the data register (`reg_addr` = 0) stores `wdata`. While `reg_addr` = 0, `rdata` shows the stored value in the same cycle.
- R2: With the strobe-enable bit (control bit 7) at 1, either a read or a write of the data register starts a sequence. A read or write of the control register (`reg_addr` = 1) starts none.
- R3: Call the clock edge that samples the triggering access edge 0. `strobe_n` is low after edges 7 to 14, which is 8 clocks, and high again after edge 15.
- R4: A data-register access sampled at edges 1 to 15 of a running sequence produces no pulse and does not shift the current one. An access at edge 16 or later starts a fresh sequence with the same timing.
- R5: With control bit 7 at 0, data-register accesses start no sequence. `strobe_n` stays high and `busy` stays low.
- R6: With the busy-enable bit (control bit 6) at 0, `busy` is low. With it at 1, `busy` is high after edges 0 to 14 of a sequence, then low again.
- R7: Control bits 1:0 always read as 1 and ignore writes. Bits 5:2 read as 0. Bits 7 and 6 read back what was written.
- R8: After reset, `strobe_n` is high, `busy` is low, the data register reads 0x00 and the control register reads 0x03.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 1 | Register select: 0 data, 1 control |
| rd_en | input | 1 | Bus read strobe for the selected register |
| wr_en | input | 1 | Bus write strobe for the selected register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register |
| strobe_n | output | 1 | Active-low handshake strobe |
| busy | output | 1 | Busy indication, high while a sequence runs |

## Verification
Register results are combinational on `rdata`, so they are read a short delay after the select is driven, in the same cycle. Strobe and busy results are timed from the edge that samples the access. The bench drives each access at a falling edge and counts rising edges from there. It then compares `strobe_n` and `busy` at the falling edge after each of the next 40 rising edges. Each comparison uses a pattern computed from the delay, width and window numbers. Accesses inside the lockout window are injected at chosen edge numbers (1, 8, 15, 16) within that same count.

// File: rtl/pstb_pkg.sv
package pstb_pkg;

   typedef enum logic {
      ADDR_DATA = 1'b0,
      ADDR_CTRL = 1'b1
   } pstb_addr_e;

   localparam int CTL_STB_EN_BIT  = 7;
   localparam int CTL_BUSY_EN_BIT = 6;

   localparam logic [7:0] CTRL_WR_MASK   = 8'hC0;
   localparam logic [7:0] CTRL_ONES_MASK = 8'h03;
   localparam logic [7:0] CTRL_RST_VAL   = 8'h00;

endpackage

// File: rtl/pstb_data_reg.sv
module pstb_data_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_req,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("pstb_data_reg: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (wr_req) q <= wdata;
   end

endmodule

// File: rtl/pstb_ctrl_reg.sv
module pstb_ctrl_reg #(
   parameter int             W         = 8,
   parameter logic [W-1:0]   WR_MASK   = '0,
   parameter logic [W-1:0]   ONES_MASK = '0,
   parameter logic [W-1:0]   RST_VAL   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_req,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   if ((WR_MASK & ONES_MASK) != '0) begin : g_bad_mask
      $error("pstb_ctrl_reg: a bit cannot be both writable and fixed at one");
   end

   for (genvar b = 0; b < W; b++) begin : g_bit
      if (ONES_MASK[b]) begin : g_one
         assign q[b] = 1'b1;
      end else if (WR_MASK[b]) begin : g_ff
         logic bit_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      bit_q <= RST_VAL[b];
            else if (wr_req) bit_q <= wdata[b];
         end
         assign q[b] = bit_q;
      end else begin : g_zero
         assign q[b] = 1'b0;
      end
   end

endmodule

// File: rtl/pstb_sequencer.sv
module pstb_sequencer #(
   parameter int DELAY  = 7,
   parameter int WIDTH  = 8,
   parameter int WINDOW = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_req,
   input  logic enable,
   input  logic busy_en,
   output logic strobe_n,
   output logic busy
);

   localparam int CW = $clog2(WINDOW + 1);
   localparam logic [CW-1:0] LOW_FIRST = CW'(DELAY + 1);
   localparam logic [CW-1:0] LOW_LAST  = CW'(DELAY + WIDTH);
   localparam logic [CW-1:0] WIN_END   = CW'(WINDOW);
   localparam logic [CW-1:0] AFTER_LOW = (DELAY + WIDTH == WINDOW) ? '0 : CW'(DELAY + WIDTH + 1);

   if (DELAY < 1) begin : g_bad_delay
      $error("pstb_sequencer: DELAY must be at least 1");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("pstb_sequencer: WIDTH must be at least 1");
   end
   if (WINDOW < DELAY + WIDTH) begin : g_bad_window
      $error("pstb_sequencer: WINDOW must cover DELAY + WIDTH");
   end

   // cnt_q is k+1 after edge k of a sequence; 0 means idle
   logic [CW-1:0] cnt_q, cnt_d;
   logic          active, in_low;

   assign active = (cnt_q != '0);

   always_comb begin
      cnt_d = cnt_q;
      if (!active) begin
         if (trig_req && enable) cnt_d = CW'(1);
      end else if (cnt_q == WIN_END) begin
         cnt_d = '0;
      end else begin
         cnt_d = cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign in_low   = active && (cnt_q >= LOW_FIRST) && (cnt_q <= LOW_LAST);
   assign strobe_n = !(in_low && enable);
   assign busy     = busy_en && active && (cnt_q <= LOW_LAST);

   AST_FALL_AT_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(strobe_n) && $past(enable) |-> cnt_q == LOW_FIRST); // R3
   AST_RISE_AFTER_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe_n) && enable |-> cnt_q == AFTER_LOW); // R3
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      trig_req && active |=> cnt_q != CW'(1)); // R4
   AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !active && !enable |=> !active && strobe_n); // R5
   AST_BUSY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_en |-> !busy); // R6

endmodule

// File: rtl/strobe_port_ctrl.sv
module strobe_port_ctrl #(
   parameter int DATA_W      = 8,
   parameter int STB_DELAY   = 7,
   parameter int STB_WIDTH   = 8,
   parameter int LOCK_WINDOW = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_addr,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              strobe_n,
   output logic              busy
);
   import pstb_pkg::*;

   localparam logic [DATA_W-1:0] WR_MASK   = DATA_W'(CTRL_WR_MASK);
   localparam logic [DATA_W-1:0] ONES_MASK = DATA_W'(CTRL_ONES_MASK);
   localparam logic [DATA_W-1:0] RST_VAL   = DATA_W'(CTRL_RST_VAL);

   if (DATA_W < 8) begin : g_bad_dw
      $error("strobe_port_ctrl: DATA_W must hold the control bits");
   end

   logic              sel_data, sel_ctrl, data_access;
   logic [DATA_W-1:0] data_q, ctrl_q;

   assign sel_data    = (reg_addr == ADDR_DATA);
   assign sel_ctrl    = (reg_addr == ADDR_CTRL);
   assign data_access = sel_data && (rd_en || wr_en);

   pstb_data_reg #(.W(DATA_W)) u_data (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_req (wr_en && sel_data),
      .wdata  (wdata),
      .q      (data_q)
   );

   pstb_ctrl_reg #(
      .W         (DATA_W),
      .WR_MASK   (WR_MASK),
      .ONES_MASK (ONES_MASK),
      .RST_VAL   (RST_VAL)
   ) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_req (wr_en && sel_ctrl),
      .wdata  (wdata),
      .q      (ctrl_q)
   );

   pstb_sequencer #(
      .DELAY  (STB_DELAY),
      .WIDTH  (STB_WIDTH),
      .WINDOW (LOCK_WINDOW)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig_req (data_access),
      .enable   (ctrl_q[CTL_STB_EN_BIT]),
      .busy_en  (ctrl_q[CTL_BUSY_EN_BIT]),
      .strobe_n (strobe_n),
      .busy     (busy)
   );

   assign rdata = sel_ctrl ? ctrl_q : data_q;

   AST_RSVD_READ_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      sel_ctrl |-> rdata[1:0] == 2'b11); // R7
   AST_DATA_STORED: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && sel_data |=> sel_ctrl || rdata == $past(wdata)); // R1
   AST_CTRL_NO_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
      sel_ctrl && strobe_n && !busy && !ctrl_q[CTL_STB_EN_BIT] |=> strobe_n); // R2

endmodule

// File: tb/tb_strobe_port_ctrl.sv
module tb_strobe_port_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int DLY = 7;
   localparam int WID = 8;
   localparam int WIN = 15;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_addr = 1'b0;
   logic       rd_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       strobe_n, busy;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   strobe_port_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .rd_en(rd_en),
      .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
      .strobe_n(strobe_n), .busy(busy)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic reg_write(input bit addr, input logic [7:0] val);
      @(negedge clk);
      reg_addr = addr; wdata = val; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic reg_read(input bit addr, output logic [7:0] val);
      @(negedge clk);
      reg_addr = addr;
      #1 val = rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Runs one sequence from an access at edge 0, an optional second access at edge sec_k
   task automatic seq_run(input string req, input bit use_rd, input int sec_k,
                          input bit sec_starts, input bit en, input bit ben);
      int sm = 0, bm = 0, first_s = -1, first_b = -1;
      @(negedge clk);
      reg_addr = 1'b0; wdata = 8'h3C;
      if (use_rd) rd_en = 1'b1; else wr_en = 1'b1;
      for (int k = 0; k < 40; k++) begin
         bit exp_low, exp_busy;
         int d;
         @(posedge clk);
         @(negedge clk);
         rd_en = 1'b0; wr_en = 1'b0;
         if (sec_k > 0 && k + 1 == sec_k) begin
            if (use_rd) rd_en = 1'b1; else wr_en = 1'b1;
         end
         exp_low  = en && (k >= DLY) && (k <= DLY + WID - 1);
         exp_busy = en && ben && (k <= DLY + WID - 1);
         if (sec_starts && k >= sec_k) begin
            d = k - sec_k;
            if (en && d >= DLY && d <= DLY + WID - 1) exp_low = 1'b1;
            if (en && ben && d <= DLY + WID - 1) exp_busy = 1'b1;
         end
         if (strobe_n != !exp_low) begin sm++; if (first_s < 0) first_s = k; end
         if (busy != exp_busy) begin bm++; if (first_b < 0) first_b = k; end
      end
      check(req, $sformatf("strobe_n pattern mismatches (first at edge %0d)", first_s), sm, 0);
      check(req, $sformatf("busy pattern mismatches (first at edge %0d)", first_b), bm, 0);
      idle(4);
   endtask

   task automatic t_reset;
      logic [7:0] v;
      check("R8", "strobe_n after reset", strobe_n, 1);
      check("R8", "busy after reset", busy, 0);
      reg_read(1'b0, v); check("R8", "data after reset", v, 8'h00);
      reg_read(1'b1, v); check("R8", "ctrl after reset", v, 8'h03);
   endtask

   task automatic t_data_rw;
      logic [7:0] v;
      reg_write(1'b0, 8'hA5);
      reg_read(1'b0, v); check("R1", "data readback A5", v, 8'hA5);
      reg_write(1'b0, 8'h5A);
      reg_read(1'b0, v); check("R1", "data readback 5A", v, 8'h5A);
      idle(20);
   endtask

   task automatic t_ctrl_bits;
      logic [7:0] v;
      reg_write(1'b1, 8'h3C);
      reg_read(1'b1, v); check("R7", "ctrl after writing 3C", v, 8'h03);
      reg_write(1'b1, 8'hFF);
      reg_read(1'b1, v); check("R7", "ctrl after writing FF", v, 8'hC3);
      reg_write(1'b1, 8'h80);
      reg_read(1'b1, v); check("R7", "ctrl after writing 80", v, 8'h83);
   endtask

   task automatic t_ctrl_access_quiet;
      int bad = 0;
      reg_write(1'b1, 8'hC0);
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         reg_addr = 1'b1; rd_en = (k == 0);
         if (!strobe_n || busy) bad++;
      end
      rd_en = 1'b0;
      check("R2", "pulses after control register access", bad, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_data_rw();
      t_ctrl_bits();
      seq_run("R3", 1'b0, 0, 1'b0, 1'b1, 1'b0);   // write trigger, busy off (R6)
      reg_write(1'b1, 8'hC0); idle(20);
      seq_run("R2", 1'b1, 0, 1'b0, 1'b1, 1'b1);   // read trigger, busy on (R6)
      t_ctrl_access_quiet();
      seq_run("R4", 1'b0, 1, 1'b0, 1'b1, 1'b1);
      seq_run("R4", 1'b1, 8, 1'b0, 1'b1, 1'b1);
      seq_run("R4", 1'b0, 15, 1'b0, 1'b1, 1'b1);
      seq_run("R4", 1'b0, 16, 1'b1, 1'b1, 1'b1);
      reg_write(1'b1, 8'h40); idle(20);
      seq_run("R5", 1'b0, 0, 1'b0, 1'b0, 1'b1);
      reg_write(1'b1, 8'h00); idle(2);
      seq_run("R6", 1'b1, 0, 1'b0, 1'b0, 1'b0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog all-requirements actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule